// File: doc/BRIEF.md
# Privilege-Banked Register File

This block is the architectural register storage for a processor core that runs in several privilege modes. It holds sixteen visible 32-bit registers, read through two combinational ports and written through one synchronous port, plus a visible saved-status register with its own read and write port. Behind the visible set sit shadow copies. There is a stack-pointer, link and saved-status copy for each of six banks, and two alternative sets for registers 8 to 12.

The core's exception sequencer asks for a mode change by presenting a 5-bit mode code with a valid strobe. If the requested mode maps to a different bank than the current one, the block swaps register 13, register 14 and the saved-status register at that clock edge. The outgoing values go to the old bank and the incoming values come from the new bank. Registers 8 to 12 are swapped as well, between a fast-interrupt set and a shared set, when exactly one of the two modes is the fast-interrupt mode. Instruction decode, the ALU and the exception entry sequence all live outside the block.

Top module: `mbank_regfile`

## Requirements
- R1: While reset is low and after it is released, all sixteen visible registers, every shadow copy and the saved-status register read zero. The current mode reads 5'b11111 (system).
- R2: Mode codes are user 5'b10000, fast interrupt 5'b10001, interrupt 5'b10010, supervisor 5'b10011, abort 5'b10111, undefined 5'b11011 and system 5'b11111. Any other code maps to the bank used by user and system. When `mode_req_valid` is high, `cur_mode` shows the requested code from the next cycle on.
- R3: On a mode change whose bank differs from the current one, registers 13 and 14 are stored into the old mode's bank. Their new values are loaded from the new mode's bank, and they return the stored values when the old bank is entered again.
- R4: On such a bank change, the saved-status value is stored into the old bank and the new bank's saved value becomes visible. With no write and no bank change it holds its value.
- R5: Registers 8 to 12 are exchanged only when one of the old and new modes is fast interrupt and the other is not. The exchange is between the fast-interrupt set and a single set shared by all other modes.
- R6: A request for the current mode, or for any mode mapping to the same bank (user and system share one bank), changes no register and no saved-status value.
- R7: A register or saved-status write in the same cycle as a mode change lands in the register visible before the swap. For registers 13, 14 and 8 to 12 and for saved status, that value is the one stored into the old bank.
- R8: Both read ports return the visible register selected by their address combinationally. A write becomes readable on both ports from the cycle after it is issued.
- R9: Registers 0 to 7 and 15 are never swapped by any mode change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| rd_addr_a | input | 4 | Read port A register index |
| rd_data_a | output | 32 | Read port A data |
| rd_addr_b | input | 4 | Read port B register index |
| rd_data_b | output | 32 | Read port B data |
| wr_en | input | 1 | Register write enable |
| wr_addr | input | 4 | Register write index |
| wr_data | input | 32 | Register write data |
| mode_req_valid | input | 1 | Mode change request strobe |
| mode_req | input | 5 | Requested mode code |
| cur_mode | output | 5 | Mode currently in effect |
| sts_wr_en | input | 1 | Saved-status write enable |
| sts_wr_data | input | 32 | Saved-status write data |
| sts_rd_data | output | 32 | Visible saved-status value |

## Verification
The bound checker watches on every cycle that the mode output follows each request and holds without one. It also checks that the stack pointer and saved status do not move unless a write or a bank swap explains it, and that a high-register exchange never happens without a bank swap. Whether the right values come back from the right bank cannot be judged cycle by cycle. The round trips through fast interrupt, interrupt, supervisor, abort and undefined modes show it, as do same-bank requests, unknown codes and writes that coincide with a swap. The bench scenarios check these against its own model of the banks.

// File: rtl/mbank_pkg.sv
package mbank_pkg;
  localparam int NUM_REGS  = 16;
  localparam int ADDR_W    = $clog2(NUM_REGS);
  localparam int MODE_W    = 5;
  localparam int NUM_BANKS = 6;
  localparam int HI_BASE   = 8;
  localparam int HI_CNT    = 5;
  localparam int SP_IDX    = 13;
  localparam int LR_IDX    = 14;

  localparam logic [MODE_W-1:0] MODE_USR = 5'b10000;
  localparam logic [MODE_W-1:0] MODE_FIQ = 5'b10001;
  localparam logic [MODE_W-1:0] MODE_IRQ = 5'b10010;
  localparam logic [MODE_W-1:0] MODE_SVC = 5'b10011;
  localparam logic [MODE_W-1:0] MODE_ABT = 5'b10111;
  localparam logic [MODE_W-1:0] MODE_UND = 5'b11011;
  localparam logic [MODE_W-1:0] MODE_SYS = 5'b11111;

  typedef enum logic [2:0] {
    BK_PLAIN = 3'd0,
    BK_FAST  = 3'd1,
    BK_INTR  = 3'd2,
    BK_SUPV  = 3'd3,
    BK_ABRT  = 3'd4,
    BK_UNDF  = 3'd5
  } bank_e;

  // Map a mode code onto its shadow bank; unknown codes use the plain bank.
  function automatic bank_e mode_bank(input logic [MODE_W-1:0] m);
    case (m)
      MODE_FIQ: mode_bank = BK_FAST;
      MODE_IRQ: mode_bank = BK_INTR;
      MODE_SVC: mode_bank = BK_SUPV;
      MODE_ABT: mode_bank = BK_ABRT;
      MODE_UND: mode_bank = BK_UNDF;
      default:  mode_bank = BK_PLAIN;
    endcase
  endfunction

  // True when register index r lies in the fast-interrupt high window.
  function automatic logic in_hi_window(input int r);
    in_hi_window = (r >= HI_BASE) && (r < HI_BASE + HI_CNT);
  endfunction
endpackage

// File: rtl/mbank_swap_ctrl.sv
module mbank_swap_ctrl
  import mbank_pkg::*;
(
  input  logic [MODE_W-1:0] cur_mode,
  input  logic              req_valid,
  input  logic [MODE_W-1:0] req_mode,
  output bank_e             old_bank,
  output bank_e             new_bank,
  output logic              bank_swap,
  output logic              hi_swap,
  output logic              old_is_fast,
  output logic              new_is_fast
);
  always_comb begin
    old_bank    = mode_bank(cur_mode);
    new_bank    = mode_bank(req_mode);
    old_is_fast = (old_bank == BK_FAST);
    new_is_fast = (new_bank == BK_FAST);
    bank_swap   = req_valid && (old_bank != new_bank);
    hi_swap     = bank_swap && (old_is_fast != new_is_fast);
  end
endmodule

// File: rtl/mbank_shadow_store.sv
module mbank_shadow_store
  import mbank_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int STS_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              swap,
  input  bank_e             old_bank,
  input  bank_e             new_bank,
  input  logic [DATA_W-1:0] save_sp,
  input  logic [DATA_W-1:0] save_lr,
  input  logic [STS_W-1:0]  save_sts,
  output logic [DATA_W-1:0] load_sp,
  output logic [DATA_W-1:0] load_lr,
  output logic [STS_W-1:0]  load_sts
);
  logic [DATA_W-1:0] sp_arr  [NUM_BANKS];
  logic [DATA_W-1:0] lr_arr  [NUM_BANKS];
  logic [STS_W-1:0]  sts_arr [NUM_BANKS];

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic [DATA_W-1:0] sp_r;
    logic [DATA_W-1:0] lr_r;
    logic [STS_W-1:0]  sts_r;
    logic              take;

    assign take = swap && (old_bank == bank_e'(b));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        sp_r  <= '0;
        lr_r  <= '0;
        sts_r <= '0;
      end else if (take) begin
        sp_r  <= save_sp;
        lr_r  <= save_lr;
        sts_r <= save_sts;
      end
    end

    assign sp_arr[b]  = sp_r;
    assign lr_arr[b]  = lr_r;
    assign sts_arr[b] = sts_r;
  end

  always_comb begin
    load_sp  = sp_arr[new_bank];
    load_lr  = lr_arr[new_bank];
    load_sts = sts_arr[new_bank];
  end
endmodule

// File: rtl/mbank_hi_store.sv
module mbank_hi_store
  import mbank_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         hi_swap,
  input  logic                         old_is_fast,
  input  logic                         new_is_fast,
  input  logic [HI_CNT-1:0][DATA_W-1:0] save_vals,
  output logic [HI_CNT-1:0][DATA_W-1:0] load_vals
);
  localparam int NUM_SETS = 2;

  logic [HI_CNT-1:0][DATA_W-1:0] set_arr [NUM_SETS];

  for (genvar s = 0; s < NUM_SETS; s++) begin : g_set
    logic [HI_CNT-1:0][DATA_W-1:0] vals_r;
    logic                          take;

    assign take = hi_swap && (old_is_fast == (s == 1));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        vals_r <= '0;
      end else if (take) begin
        vals_r <= save_vals;
      end
    end

    assign set_arr[s] = vals_r;
  end

  assign load_vals = new_is_fast ? set_arr[1] : set_arr[0];
endmodule

// File: rtl/mbank_regfile.sv
module mbank_regfile
  import mbank_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int STS_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [3:0]        rd_addr_a,
  output logic [DATA_W-1:0] rd_data_a,
  input  logic [3:0]        rd_addr_b,
  output logic [DATA_W-1:0] rd_data_b,
  input  logic              wr_en,
  input  logic [3:0]        wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              mode_req_valid,
  input  logic [4:0]        mode_req,
  output logic [4:0]        cur_mode,
  input  logic              sts_wr_en,
  input  logic [STS_W-1:0]  sts_wr_data,
  output logic [STS_W-1:0]  sts_rd_data
);
  logic [DATA_W-1:0] vis_q  [NUM_REGS];
  logic [DATA_W-1:0] vis_wr [NUM_REGS];
  logic [DATA_W-1:0] vis_d  [NUM_REGS];
  logic [STS_W-1:0]  sts_q, sts_wr, sts_d;
  logic [MODE_W-1:0] mode_q;

  bank_e old_bank, new_bank;
  logic  bank_swap, hi_swap, old_is_fast, new_is_fast;

  logic [DATA_W-1:0] load_sp, load_lr;
  logic [STS_W-1:0]  load_sts;
  logic [HI_CNT-1:0][DATA_W-1:0] hi_save, hi_load;

  // Named observation points for the checker
  logic [DATA_W-1:0] sp_now;
  logic [DATA_W-1:0] lr_now;

  mbank_swap_ctrl u_ctrl (
    .cur_mode    (mode_q),
    .req_valid   (mode_req_valid),
    .req_mode    (mode_req),
    .old_bank    (old_bank),
    .new_bank    (new_bank),
    .bank_swap   (bank_swap),
    .hi_swap     (hi_swap),
    .old_is_fast (old_is_fast),
    .new_is_fast (new_is_fast)
  );

  // Write first: the pre-swap register takes the write, then it is saved.
  always_comb begin
    for (int r = 0; r < NUM_REGS; r++) begin
      vis_wr[r] = (wr_en && (wr_addr == ADDR_W'(r))) ? wr_data : vis_q[r];
    end
    sts_wr = sts_wr_en ? sts_wr_data : sts_q;
  end

  for (genvar k = 0; k < HI_CNT; k++) begin : g_hi_pack
    assign hi_save[k] = vis_wr[HI_BASE + k];
  end

  mbank_shadow_store #(.DATA_W(DATA_W), .STS_W(STS_W)) u_shadow (
    .clk      (clk),
    .rst_n    (rst_n),
    .swap     (bank_swap),
    .old_bank (old_bank),
    .new_bank (new_bank),
    .save_sp  (vis_wr[SP_IDX]),
    .save_lr  (vis_wr[LR_IDX]),
    .save_sts (sts_wr),
    .load_sp  (load_sp),
    .load_lr  (load_lr),
    .load_sts (load_sts)
  );

  mbank_hi_store #(.DATA_W(DATA_W)) u_hi (
    .clk         (clk),
    .rst_n       (rst_n),
    .hi_swap     (hi_swap),
    .old_is_fast (old_is_fast),
    .new_is_fast (new_is_fast),
    .save_vals   (hi_save),
    .load_vals   (hi_load)
  );

  always_comb begin
    for (int r = 0; r < NUM_REGS; r++) begin
      vis_d[r] = vis_wr[r];
      if (hi_swap && in_hi_window(r)) begin
        vis_d[r] = hi_load[r - HI_BASE];
      end
    end
    if (bank_swap) begin
      vis_d[SP_IDX] = load_sp;
      vis_d[LR_IDX] = load_lr;
    end
    sts_d = bank_swap ? load_sts : sts_wr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int r = 0; r < NUM_REGS; r++) vis_q[r] <= '0;
      sts_q  <= '0;
      mode_q <= MODE_SYS;
    end else begin
      for (int r = 0; r < NUM_REGS; r++) vis_q[r] <= vis_d[r];
      sts_q <= sts_d;
      if (mode_req_valid) mode_q <= mode_req;
    end
  end

  assign sp_now      = vis_q[SP_IDX];
  assign lr_now      = vis_q[LR_IDX];
  assign rd_data_a   = vis_q[rd_addr_a];
  assign rd_data_b   = vis_q[rd_addr_b];
  assign sts_rd_data = sts_q;
  assign cur_mode    = mode_q;
endmodule

// File: rtl/mbank_regfile_chk.sv
module mbank_regfile_chk #(
  parameter int DATA_W = 32,
  parameter int STS_W  = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              mode_req_valid,
  input logic [4:0]        mode_req,
  input logic [4:0]        cur_mode,
  input logic              bank_swap,
  input logic              hi_swap,
  input logic              wr_en,
  input logic [3:0]        wr_addr,
  input logic              sts_wr_en,
  input logic [STS_W-1:0]  sts_rd_data,
  input logic [DATA_W-1:0] sp_now
);
  assert_mode_follow_R2: assert property (@(posedge clk) disable iff (!rst_n)
    mode_req_valid |=> cur_mode == $past(mode_req));

  assert_mode_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_req_valid |=> $stable(cur_mode));

  assert_sp_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!bank_swap && !(wr_en && wr_addr == 4'd13)) |=> $stable(sp_now));

  assert_sts_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!bank_swap && !sts_wr_en) |=> $stable(sts_rd_data));

  assert_hi_needs_bank_R5: assert property (@(posedge clk) disable iff (!rst_n)
    hi_swap |-> bank_swap);
endmodule

bind mbank_regfile mbank_regfile_chk #(.DATA_W(DATA_W), .STS_W(STS_W)) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .mode_req_valid (mode_req_valid),
  .mode_req       (mode_req),
  .cur_mode       (cur_mode),
  .bank_swap      (bank_swap),
  .hi_swap        (hi_swap),
  .wr_en          (wr_en),
  .wr_addr        (wr_addr),
  .sts_wr_en      (sts_wr_en),
  .sts_rd_data    (sts_rd_data),
  .sp_now         (sp_now)
);

// File: tb/sim_mbank_regfile.sv
`timescale 1ns/1ps
module sim_mbank_regfile;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  rd_addr_a = '0, rd_addr_b = '0, wr_addr = '0;
  logic [31:0] rd_data_a, rd_data_b, wr_data = '0, sts_wr_data = '0, sts_rd_data;
  logic        wr_en = 1'b0, mode_req_valid = 1'b0, sts_wr_en = 1'b0;
  logic [4:0]  mode_req = '0, cur_mode;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  mbank_regfile u0 (
    .clk(clk), .rst_n(rst_n),
    .rd_addr_a(rd_addr_a), .rd_data_a(rd_data_a),
    .rd_addr_b(rd_addr_b), .rd_data_b(rd_data_b),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .mode_req_valid(mode_req_valid), .mode_req(mode_req), .cur_mode(cur_mode),
    .sts_wr_en(sts_wr_en), .sts_wr_data(sts_wr_data), .sts_rd_data(sts_rd_data)
  );

  // Bench model: banks 0 plain, 1 fast, 2 irq, 3 svc, 4 abort, 5 undef
  logic [31:0] m_vis [16];
  logic [31:0] m_sp [6], m_lr [6], m_ss [6];
  logic [31:0] m_hi [2][5];
  logic [31:0] m_sts;
  logic [4:0]  m_mode;

  function automatic int bench_bank(input logic [4:0] m);
    if (m == 5'b10001) return 1;
    if (m == 5'b10010) return 2;
    if (m == 5'b10011) return 3;
    if (m == 5'b10111) return 4;
    if (m == 5'b11011) return 5;
    return 0;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < 16; i++) m_vis[i] = '0;
    for (int b = 0; b < 6; b++) begin m_sp[b] = '0; m_lr[b] = '0; m_ss[b] = '0; end
    for (int s = 0; s < 2; s++) for (int k = 0; k < 5; k++) m_hi[s][k] = '0;
    m_sts = '0;
    m_mode = 5'b11111;
  endtask

  // One cycle of stimulus, driven after a falling edge; model updated after.
  task automatic op(input bit we, input int wa, input logic [31:0] wd,
                    input bit se, input logic [31:0] sd,
                    input bit mv, input logic [4:0] mc);
    int ob, nb;
    wr_en = we; wr_addr = 4'(wa); wr_data = wd;
    sts_wr_en = se; sts_wr_data = sd;
    mode_req_valid = mv; mode_req = mc;
    @(negedge clk);
    wr_en = 1'b0; sts_wr_en = 1'b0; mode_req_valid = 1'b0;
    if (we) m_vis[wa] = wd;
    if (se) m_sts = sd;
    if (mv) begin
      ob = bench_bank(m_mode);
      nb = bench_bank(mc);
      if (ob != nb) begin
        if ((ob == 1) != (nb == 1)) begin
          for (int k = 0; k < 5; k++) begin
            m_hi[(ob == 1) ? 1 : 0][k] = m_vis[8 + k];
            m_vis[8 + k] = m_hi[(nb == 1) ? 1 : 0][k];
          end
        end
        m_sp[ob] = m_vis[13]; m_lr[ob] = m_vis[14]; m_ss[ob] = m_sts;
        m_vis[13] = m_sp[nb]; m_vis[14] = m_lr[nb]; m_sts = m_ss[nb];
      end
      m_mode = mc;
    end
  endtask

  task automatic check_state(input string tag);
    for (int i = 0; i < 16; i++) begin
      rd_addr_a = 4'(i);
      rd_addr_b = 4'(15 - i);
      #0.05;
      chk({tag, " portA"}, rd_data_a, m_vis[i]);
      chk({tag, " portB"}, rd_data_b, m_vis[15 - i]);
    end
    chk({tag, " status"}, sts_rd_data, m_sts);
    chk({tag, " mode"}, {27'd0, cur_mode}, {27'd0, m_mode});
  endtask

  task automatic fill(input logic [31:0] seed);
    for (int i = 0; i < 16; i++) op(1'b1, i, seed + 32'(i) * 32'h0101_0101, 1'b0, '0, 1'b0, '0);
  endtask

  task automatic t_reset();
    check_state("R1 reset");
  endtask

  task automatic t_write_read();
    fill(32'hA000_0000);
    check_state("R8 write/read");
  endtask

  task automatic t_fast_swap();
    op(1'b0, 0, '0, 1'b1, 32'h5151_0001, 1'b0, '0);
    op(1'b0, 0, '0, 1'b0, '0, 1'b1, 5'b10001);
    check_state("R5 R9 enter fast");
    for (int r = 8; r < 15; r++) op(1'b1, r, 32'hF00D_0000 + 32'(r), 1'b0, '0, 1'b0, '0);
    op(1'b0, 0, '0, 1'b1, 32'h0F0F_0F0F, 1'b0, '0);
    op(1'b0, 0, '0, 1'b0, '0, 1'b1, 5'b11111);
    check_state("R3 R5 leave fast");
    op(1'b0, 0, '0, 1'b0, '0, 1'b1, 5'b10001);
    check_state("R3 R4 R5 re-enter fast");
    op(1'b0, 0, '0, 1'b0, '0, 1'b1, 5'b11111);
  endtask

  task automatic t_irq_svc();
    op(1'b0, 0, '0, 1'b0, '0, 1'b1, 5'b10010);
    op(1'b1, 13, 32'h1111_D000, 1'b0, '0, 1'b0, '0);
    op(1'b1, 14, 32'h1111_E000, 1'b1, 32'h1111_5555, 1'b0, '0);
    op(1'b0, 0, '0, 1'b0, '0, 1'b1, 5'b10011);
    check_state("R3 R4 irq to svc");
    op(1'b1, 13, 32'h2222_D000, 1'b1, 32'h2222_5555, 1'b0, '0);
    op(1'b0, 0, '0, 1'b0, '0, 1'b1, 5'b10010);
    check_state("R3 R4 R5 svc back to irq");
    op(1'b0, 0, '0, 1'b0, '0, 1'b1, 5'b10011);
    check_state("R4 R9 irq to svc again");
  endtask

  task automatic t_same_bank();
    op(1'b0, 0, '0, 1'b0, '0, 1'b1, 5'b11111);
    op(1'b1, 13, 32'h3333_D000, 1'b1, 32'h3333_5555, 1'b0, '0);
    op(1'b0, 0, '0, 1'b0, '0, 1'b1, 5'b10000);
    check_state("R6 sys to user");
    op(1'b0, 0, '0, 1'b0, '0, 1'b1, 5'b10000);
    check_state("R6 user to user");
    op(1'b0, 0, '0, 1'b0, '0, 1'b1, 5'b10100);
    check_state("R2 R6 unknown code");
    op(1'b0, 0, '0, 1'b0, '0, 1'b1, 5'b11111);
    check_state("R6 back to sys");
  endtask

  task automatic t_concurrent();
    op(1'b1, 13, 32'h4444_D000, 1'b1, 32'h4444_5555, 1'b1, 5'b10111);
    check_state("R7 write with abort entry");
    op(1'b1, 10, 32'h4444_A000, 1'b0, '0, 1'b1, 5'b10001);
    check_state("R7 high write with fast entry");
    op(1'b0, 0, '0, 1'b0, '0, 1'b1, 5'b10111);
    check_state("R7 R5 fast to abort");
    op(1'b0, 0, '0, 1'b0, '0, 1'b1, 5'b11111);
    check_state("R7 abort to sys");
  endtask

  task automatic t_undef();
    op(1'b0, 0, '0, 1'b0, '0, 1'b1, 5'b11011);
    op(1'b1, 14, 32'h5555_E000, 1'b1, 32'h5555_5555, 1'b0, '0);
    op(1'b0, 0, '0, 1'b0, '0, 1'b1, 5'b10111);
    op(1'b0, 0, '0, 1'b0, '0, 1'b1, 5'b11011);
    check_state("R2 R3 undef round trip");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_write_read();
    t_fast_swap();
    t_irq_svc();
    t_same_bank();
    t_concurrent();
    t_undef();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule